// File: doc/BRIEF.md
# Debug-Port Command and Memory-Access Engine

This block sits behind the byte receiver of a single-wire debug port. It turns a stream of received command bytes into byte-wide transactions on a request/acknowledge bus, and it returns read results as single-cycle response bytes. It is a bus master in its own right. It keeps its own access pointer and a small private register bank that lies outside the memory map. That bank holds the permission flags, a sticky access-error flag and the hold line for the target CPU reset.

Every command starts with one command byte. The engine supports four kinds of memory access:
- loads from an address carried in the command, where two address bytes follow the command byte, low byte first;
- stores to such an address;
- loads through the pointer, with an optional post-increment;
- stores through the pointer, with the same option.

A set-pointer command loads the pointer. Two further commands read and write the private registers. Accesses to the upper, non-volatile region need the programming permission. Accesses to the debug page need the debug permission. A refused access never reaches the bus.

The state machine has six states:
- CMD: waits for a command byte.
- ALO: takes the low address byte.
- AHI: takes the high address byte.
- DATA: takes a store byte.
- BUS: runs or refuses the access.
- RESP: presents the response byte.

The transitions are these:
- CMD→ALO for direct load, direct store and set-pointer.
- CMD→BUS for a pointer load.
- CMD→DATA for a pointer store or a register write.
- CMD→RESP for a register read.
- CMD→CMD for the unused opcode.
- ALO→AHI always.
- AHI→CMD for set-pointer, AHI→DATA for a direct store, and AHI→BUS for a direct load.
- DATA→CMD for a register write and DATA→BUS for a store.
- BUS→RESP for loads and BUS→CMD for stores, taken on acknowledge or at once when the access is refused.
- RESP→CMD always.

Top module: `dce_top`

## Requirements
- R1: The command byte holds the opcode in bits [7:5]: 0 direct load, 1 pointer load, 2 direct store, 3 pointer store, 4 register read, 5 set pointer, 6 register write, 7 ignored with no response. Bit 4 selects post-increment for pointer accesses. Bits [1:0] select the private register.
- R2: A direct load takes two address bytes, low byte first, performs one bus read there and returns the byte read.
- R3: A direct store takes two address bytes, low byte first, then one data byte, and performs one bus write of that byte to that address.
- R4: Set-pointer loads the pointer from two bytes, low byte first. Pointer loads and stores access the pointer address. When bit 4 is set, the pointer then advances by one; when bit 4 is clear, it keeps its value.
- R5: The private registers are: index 0 status, read as {5'b0, error, debug permission, programming permission}; index 1 key; index 2 reset control in bit 0; index 3 reads as 0x00.
- R6: Writing 0xA5 to the key register grants the programming permission and writing 0x5A grants the debug permission. Any other value except 0xE7 withdraws both permissions.
- R7: An address at or above 0x8000 needs the programming permission, for reads and writes alike. An address whose upper byte is 0x7F needs the debug permission.
- R8: A refused access makes no bus transaction. A refused read returns 0x00. A refused access sets status bit 2, which stays set until a status write with bit 2 set clears it.
- R9: Writing 0xE7 to the key register raises erase_pulse for exactly one cycle, grants the programming permission and withdraws the debug permission.
- R10: Bit 0 of the reset-control register drives cpu_reset.
- R11: A response is presented for exactly one cycle. After a register read it comes in the cycle after the command byte. After a load it comes in the cycle after the bus acknowledge or the refusal.
- R12: After reset, no response, bus request, CPU reset or erase pulse is active, and the status register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Response byte valid (one cycle) |
| tx_data | output | 8 | Response byte |
| bus_req | output | 1 | Bus request, held until acknowledge |
| bus_we | output | 1 | Bus write enable |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid with acknowledge |
| bus_ack | input | 1 | Bus acknowledge |
| cpu_reset | output | 1 | Target CPU reset hold |
| erase_pulse | output | 1 | Full-erase trigger pulse |

## Verification
A register read answers in the cycle that follows the command byte. A load answers one cycle after the bus acknowledge; the bench memory acknowledges one cycle after a request, so a load answers three cycles after its last byte. A refused load answers one cycle sooner, because it makes no bus access. Register and reset-line updates take effect at the edge that accepts the data byte, and the erase pulse follows one cycle after that edge. The bench sends each command and then waits a fixed number of idle cycles, longer than the slowest of these paths. A scoreboard queue is compared at falling edges against every response the design presents. An unexpected response or a missing one is a mismatch.

// File: rtl/dce_pkg.sv
package dce_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        OP_LDD  = 3'd0,
        OP_LDP  = 3'd1,
        OP_STD  = 3'd2,
        OP_STP  = 3'd3,
        OP_LDC  = 3'd4,
        OP_SPTR = 3'd5,
        OP_STC  = 3'd6,
        OP_NOP  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_CMD, S_ALO, S_AHI, S_DATA, S_BUS, S_RESP
    } state_e;

    localparam logic [1:0] CS_STATUS = 2'd0;
    localparam logic [1:0] CS_KEY    = 2'd1;
    localparam logic [1:0] CS_RST    = 2'd2;
endpackage

// File: rtl/dce_ptr.sv
module dce_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (inc)  ptr <= ptr + 1'b1;
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (ptr == $past(ptr) + 1'b1)); // R4
    AST_PTR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(ptr)); // R4
endmodule

// File: rtl/dce_csr.sv
module dce_csr #(
    parameter int          DW       = 8,
    parameter logic [7:0]  KEY_PROG = 8'hA5,
    parameter logic [7:0]  KEY_DBG  = 8'h5A,
    parameter logic [7:0]  KEY_ERA  = 8'hE7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    rd_idx,
    input  logic          set_err,
    output logic [DW-1:0] rd_data,
    output logic          prog_key,
    output logic          dbg_key,
    output logic          cpu_reset,
    output logic          erase_pulse
);
    import dce_pkg::*;

    logic err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_key    <= 1'b0;
            dbg_key     <= 1'b0;
            err_q       <= 1'b0;
            cpu_reset   <= 1'b0;
            erase_pulse <= 1'b0;
        end else begin
            erase_pulse <= 1'b0;
            if (set_err) err_q <= 1'b1;
            if (wr_en) begin
                unique case (wr_idx)
                    CS_STATUS: if (wr_data[2]) err_q <= 1'b0;
                    CS_KEY: begin
                        if (wr_data == KEY_PROG)     prog_key <= 1'b1;
                        else if (wr_data == KEY_DBG) dbg_key  <= 1'b1;
                        else if (wr_data == KEY_ERA) begin
                            erase_pulse <= 1'b1;
                            prog_key    <= 1'b1;
                            dbg_key     <= 1'b0;
                        end else begin
                            prog_key <= 1'b0;
                            dbg_key  <= 1'b0;
                        end
                    end
                    CS_RST:  cpu_reset <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_idx)
            CS_STATUS: rd_data[2:0] = {err_q, dbg_key, prog_key};
            CS_RST:    rd_data[0]   = cpu_reset;
            default:   rd_data      = '0;
        endcase
    end

    AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |=> !erase_pulse); // R9
    AST_ERASE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        erase_pulse |-> (prog_key && !dbg_key)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !wr_en) |=> err_q); // R8
endmodule

// File: rtl/dce_guard.sv
module dce_guard #(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   PROT_BASE = 16'h8000,
    parameter logic [AW-9:0]   DBG_PAGE  = 8'h7F
) (
    input  logic [AW-1:0] addr,
    input  logic          prog_key,
    input  logic          dbg_key,
    output logic          allowed
);
    always_comb begin
        if (addr >= PROT_BASE)             allowed = prog_key;
        else if (addr[AW-1:8] == DBG_PAGE) allowed = dbg_key;
        else                               allowed = 1'b1;
    end
endmodule

// File: rtl/dce_top.sv
module dce_top #(
    parameter logic [15:0] PROT_BASE = 16'h8000,
    parameter logic [7:0]  DBG_PAGE  = 8'h7F
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        bus_req,
    output logic        bus_we,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    input  logic [7:0]  bus_rdata,
    input  logic        bus_ack,
    output logic        cpu_reset,
    output logic        erase_pulse
);
    import dce_pkg::*;

    state_e              state, state_nx;
    op_e                 op_q, op_in;
    logic                inc_q;
    logic [1:0]          idx_q;
    logic [ADDR_W-1:0]   addr_q, acc_addr, ptr;
    logic [DATA_W-1:0]   wdata_q, resp_q, csr_rd;
    logic                is_ptr, is_load, allowed, bus_done;
    logic                prog_key, dbg_key;
    logic                csr_wr, set_err, ptr_load, ptr_inc;

    assign op_in    = op_e'(rx_data[7:5]);
    assign is_ptr   = (op_q == OP_LDP) || (op_q == OP_STP);
    assign is_load  = (op_q == OP_LDD) || (op_q == OP_LDP);
    assign acc_addr = is_ptr ? ptr : addr_q;
    assign bus_done = !allowed || bus_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_CMD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_CMD: if (rx_valid) begin
                if (op_in == OP_LDD || op_in == OP_STD || op_in == OP_SPTR)
                    state_nx = S_ALO;
                else if (op_in == OP_LDP)
                    state_nx = S_BUS;
                else if (op_in == OP_STP || op_in == OP_STC)
                    state_nx = S_DATA;
                else if (op_in == OP_LDC)
                    state_nx = S_RESP;
            end
            S_ALO:  if (rx_valid) state_nx = S_AHI;
            S_AHI:  if (rx_valid) begin
                if (op_q == OP_SPTR)     state_nx = S_CMD;
                else if (op_q == OP_STD) state_nx = S_DATA;
                else                     state_nx = S_BUS;
            end
            S_DATA: if (rx_valid) state_nx = (op_q == OP_STC) ? S_CMD : S_BUS;
            S_BUS:  if (bus_done) state_nx = is_load ? S_RESP : S_CMD;
            S_RESP: state_nx = S_CMD;
            default: state_nx = S_CMD;
        endcase
    end

    // captured command fields and data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_NOP;
            inc_q   <= 1'b0;
            idx_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            resp_q  <= '0;
        end else begin
            unique case (state)
                S_CMD: if (rx_valid) begin
                    op_q  <= op_in;
                    inc_q <= rx_data[4];
                    idx_q <= rx_data[1:0];
                    if (op_in == OP_LDC) resp_q <= csr_rd;
                end
                S_ALO:  if (rx_valid) addr_q[7:0]        <= rx_data;
                S_AHI:  if (rx_valid) addr_q[ADDR_W-1:8] <= rx_data;
                S_DATA: if (rx_valid) wdata_q            <= rx_data;
                S_BUS: begin
                    if (!allowed)     resp_q <= '0;
                    else if (bus_ack) resp_q <= bus_rdata;
                end
                default: ;
            endcase
        end
    end

    // outputs and sub-block controls
    always_comb begin
        bus_req   = (state == S_BUS) && allowed;
        bus_we    = !is_load;
        bus_addr  = acc_addr;
        bus_wdata = wdata_q;
        tx_valid  = (state == S_RESP);
        tx_data   = resp_q;
        csr_wr    = (state == S_DATA) && rx_valid && (op_q == OP_STC);
        set_err   = (state == S_BUS) && !allowed;
        ptr_load  = (state == S_AHI) && rx_valid && (op_q == OP_SPTR);
        ptr_inc   = (state == S_BUS) && is_ptr && inc_q && bus_done;
    end

    dce_ptr #(.AW(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load),
        .load_val({rx_data, addr_q[7:0]}), .inc(ptr_inc), .ptr(ptr)
    );

    dce_csr #(.DW(DATA_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(csr_wr), .wr_idx(idx_q),
        .wr_data(rx_data), .rd_idx(rx_data[1:0]), .set_err(set_err),
        .rd_data(csr_rd), .prog_key(prog_key), .dbg_key(dbg_key),
        .cpu_reset(cpu_reset), .erase_pulse(erase_pulse)
    );

    dce_guard #(.AW(ADDR_W), .PROT_BASE(PROT_BASE), .DBG_PAGE(DBG_PAGE)) u_guard (
        .addr(acc_addr), .prog_key(prog_key), .dbg_key(dbg_key), .allowed(allowed)
    );

    AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr))); // R2
    AST_PROT_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr >= PROT_BASE) |-> prog_key); // R7
    AST_DBG_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_addr < PROT_BASE && bus_addr[15:8] == DBG_PAGE) |-> dbg_key); // R7
    AST_REFUSE_NOBUS: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |-> !bus_req); // R8
endmodule

// File: tb/tb_dce_top.sv
module tb_dce_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, bus_req, bus_we, cpu_reset, erase_pulse;
    logic [7:0]  tx_data, bus_wdata;
    logic [15:0] bus_addr;
    logic [7:0]  bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int n_cmp = 0, n_bad = 0;
    int wr_cnt = 0, era_cnt = 0;
    logic [7:0] mem [int];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    dce_top dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .cpu_reset(cpu_reset), .erase_pulse(erase_pulse)
    );

    // bus memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (bus_req && !bus_ack) begin
            if (bus_we) begin
                mem[int'(bus_addr)] = bus_wdata;
                wr_cnt++;
            end else begin
                bus_rdata <= mem.exists(int'(bus_addr)) ? mem[int'(bus_addr)] : 8'h00;
            end
        end
        bus_ack <= bus_req && !bus_ack;
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pop and compare every presented response
    always @(negedge clk) begin
        if (erase_pulse) era_cnt++;
        if (rst_n && tx_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1: actual unexpected response %0h expected none", tx_data);
            end else begin
                check(tag_q.pop_front(), tx_data, exp_q.pop_front());
            end
        end
    end

    task automatic expect_rsp(string req, logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic send(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ldd(string req, logic [15:0] a, logic [7:0] e);
        expect_rsp(req, e);
        send(8'h00); send(a[7:0]); send(a[15:8]);
        idle(6);
    endtask

    task automatic std_w(logic [15:0] a, logic [7:0] d);
        send(8'h40); send(a[7:0]); send(a[15:8]); send(d);
        idle(6);
    endtask

    task automatic sptr(logic [15:0] a);
        send(8'hA0); send(a[7:0]); send(a[15:8]);
        idle(2);
    endtask

    task automatic ldc(string req, logic [1:0] idx, logic [7:0] e);
        expect_rsp(req, e);
        send(8'h80 | {6'b0, idx});
        idle(3);
    endtask

    task automatic stc(logic [1:0] idx, logic [7:0] d);
        send(8'hC0 | {6'b0, idx}); send(d);
        idle(2);
    endtask

    int w0, e0;

    initial begin
        mem[16'h1234] = 8'h3C; mem[16'h8010] = 8'h99; mem[16'h7F05] = 8'h42;
        mem[16'h0200] = 8'h11; mem[16'h0201] = 8'h22; mem[16'h0202] = 8'h33;
        mem[16'h0203] = 8'h44;
        idle(3);
        // R12 reset state
        check("R12 tx_valid", {7'b0, tx_valid}, 8'h00);
        check("R12 bus_req", {7'b0, bus_req}, 8'h00);
        check("R12 cpu_reset", {7'b0, cpu_reset}, 8'h00);
        check("R12 erase_pulse", {7'b0, erase_pulse}, 8'h00);
        rst_n = 1'b1;
        idle(2);
        ldc("R12 status after reset", 2'd0, 8'h00);

        // R11 register read answers in the next cycle
        expect_rsp("R11 timing", 8'h00);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h80;
        @(negedge clk); rx_valid = 1'b0;
        check("R11 tx_valid next cycle", {7'b0, tx_valid}, 8'h01);
        idle(3);

        ldd("R2 direct load", 16'h1234, 8'h3C);
        std_w(16'h1300, 8'h5E);
        ldd("R3 direct store readback", 16'h1300, 8'h5E);

        // R4 pointer burst with increment, then without increment
        sptr(16'h0200);
        for (int i = 0; i < 3; i++) begin
            expect_rsp("R4 ptr inc load", 8'h11 * (i + 1));
            send(8'h30); idle(6);
        end
        for (int i = 0; i < 2; i++) begin
            expect_rsp("R4 ptr hold load", 8'h44);
            send(8'h20); idle(6);
        end
        sptr(16'h0210);
        send(8'h70); send(8'hAA); idle(6);
        send(8'h70); send(8'hBB); idle(6);
        sptr(16'h0210);
        expect_rsp("R4 ptr store 0", 8'hAA); send(8'h30); idle(6);
        expect_rsp("R4 ptr store 1", 8'hBB); send(8'h30); idle(6);

        // R7 R8 refused accesses
        ldd("R8 refused read returns zero", 16'h8010, 8'h00);
        ldc("R8 error bit set", 2'd0, 8'h04);
        w0 = wr_cnt;
        std_w(16'h8010, 8'h77);
        check("R8 refused write no bus", 8'(wr_cnt - w0), 8'h00);
        check("R8 refused write memory", mem[16'h8010], 8'h99);
        stc(2'd0, 8'h04);
        ldc("R8 error cleared", 2'd0, 8'h00);

        // R6 R7 keys
        stc(2'd1, 8'hA5);
        ldc("R6 prog permission", 2'd0, 8'h01);
        ldd("R7 protected read with key", 16'h8010, 8'h99);
        ldd("R7 debug page refused", 16'h7F05, 8'h00);
        ldc("R7 debug refusal sets error", 2'd0, 8'h05);
        stc(2'd0, 8'h04);
        stc(2'd1, 8'h5A);
        ldc("R6 both permissions", 2'd0, 8'h03);
        ldd("R7 debug page with key", 16'h7F05, 8'h42);
        stc(2'd1, 8'h00);
        ldc("R6 withdrawn", 2'd0, 8'h00);

        // R10 reset control
        stc(2'd2, 8'h01);
        check("R10 cpu_reset set", {7'b0, cpu_reset}, 8'h01);
        ldc("R10 reset reg readback", 2'd2, 8'h01);
        ldc("R5 index 3 reads zero", 2'd3, 8'h00);
        stc(2'd2, 8'h00);
        check("R10 cpu_reset clear", {7'b0, cpu_reset}, 8'h00);

        // R9 erase
        stc(2'd1, 8'h5A);
        e0 = era_cnt;
        stc(2'd1, 8'hE7);
        idle(2);
        check("R9 one erase pulse", 8'(era_cnt - e0), 8'h01);
        ldc("R9 prog granted debug withdrawn", 2'd0, 8'h01);

        // R1 unused opcode ignored
        send(8'hE0); idle(4);
        ldc("R1 engine still in step", 2'd0, 8'h01);

        idle(4);
        check("R11 no pending responses", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule